// File: doc/BRIEF.md
# Voltage Regulator Power-Up Sequencer

This block is the start-up controller of a digital multiphase voltage regulator. It takes the regulator from reset to active regulation. After a power-on reset or an external pin reset, it fetches a small set of configuration words from a nonvolatile store. It then waits in an inactive state with its phase outputs at their programmed defaults. Once the start conditions hold, it ramps the digital target voltage up from zero. Along the way it can hold at a low calibration level so that each phase can be loaded in turn. After the ramp it runs a leakage measurement, and it finally enters active regulation with power-good asserted.

The analog loop, the current sensing and the serial bus live elsewhere. Their side of the handshake is one input, `meas_done`. It tells the sequencer that the measurement it asked for (a phase calibration or the leakage measurement) has finished. If that input stays silent for too long, a fault is latched and the target is removed. Losing the run request or the supply-valid condition in any running state sends the block back to inactive at once.

Top module: `vr_powerup_seq`

## Requirements
- R1: While `rst` is high or `ext_rst_n` is low, and for the whole configuration phase that follows, `seq_state` reads 0, `ph_oe` is all zero, `pwr_ok` is 0 and `target` is 0.
- R2: Configuration reads NVM words at addresses 0, 1, 2 and 3 in that order, one request per cycle with one cycle of read latency. Once they are read, `seq_state` becomes 1 (inactive).
- R3: In the inactive state, phase k takes its mode from bits [2+2k+1:2+2k] of word 1. Mode 00 drives low (`ph_oe`=1, `ph_val`=0), mode 01 drives high (1, 1), and modes 1x give high impedance (`ph_oe`=0, `ph_val`=0).
- R4: The block leaves the inactive state only when `run_en` is 1, `vcode` is not all ones, and supply-valid holds.
- R5: Word 1 bit 0 enables the undervoltage lockout. When it is set, supply-valid equals `vin_above`. When it is clear, `vin_above` is ignored and supply-valid is true.
- R6: In the ramp states (codes 2 and 4), `target` rises by exactly one LSB every (word 0 bits [7:0] + 1) cycles, never falls, and ends at the `vcode` latched at start.
- R7: With word 1 bit 1 set, the ramp first stops at min(word 2 bits [5:0], `vcode`). The block then enters calibration (code 3), where `cal_sel` is one-hot on phase 0, then phase 1, and so on. Each phase advances on `meas_done`. After the last phase, the ramp resumes (code 4).
- R8: With word 1 bit 1 clear, `cal_sel` stays zero and the ramp goes straight from 0 to `vcode`.
- R9: After the ramp reaches `vcode`, `leak_en` is high (code 5) until `meas_done`. The block then enters active (code 6), and `pwr_ok` rises at the same edge and is 0 in every other state.
- R10: In calibration or leakage, if `meas_done` stays low for L+1 consecutive cycles, where L is word 3 bits [7:0], the block enters fault (code 7). In fault, `cal_fault` is 1 and `target` is 0, and the block stays there until reset. A `meas_done` arriving in the (L+1)-th cycle is still accepted.
- R11: In states 2 to 6, `run_en` low or supply-valid false moves the block to inactive at the next edge, with `target` 0, `pwr_ok` 0 and `cal_sel` 0.
- R12: In states 2 to 6, every phase output is driven high (`ph_oe` and `ph_val` all ones).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (internal power-on reset) |
| ext_rst_n | input | 1 | External reset, active low, sampled synchronously |
| nvm_rd | output | 1 | NVM read request |
| nvm_addr | output | NVM_AW | NVM word address |
| nvm_rdata | input | NVM_DW | NVM read data, valid one cycle after the request |
| vcode | input | VID_W | Requested output voltage code; all ones means invalid |
| run_en | input | 1 | Output enable / run request |
| vin_above | input | 1 | Input supply comparator, 1 when above threshold |
| meas_done | input | 1 | Calibration or leakage measurement finished |
| target | output | VID_W | Digital target voltage |
| pwr_ok | output | 1 | Power-good |
| ph_oe | output | NPH | Per-phase output drive enable |
| ph_val | output | NPH | Per-phase output level |
| cal_sel | output | NPH | One-hot phase under calibration load |
| leak_en | output | 1 | Leakage measurement request |
| cal_fault | output | 1 | Calibration or leakage timeout fault |
| seq_state | output | 3 | Sequencer state code |

## Verification
The bench builds the block with a 6-bit voltage code, two phases and 16-bit NVM words. This keeps every ramp under a hundred cycles.

That small build lets the bench sweep step intervals 0 to 2, both calibration settings and codes from 0 to 20, and measure the exact spacing of every ramp step. It also covers all sixteen pairs of inactive-state output modes. Timeout limits of 0 and 5 are short enough to count the fault cycle exactly, and to show that a reply in the last allowed cycle is still accepted.

// File: rtl/vr_seq_pkg.sv
package vr_seq_pkg;

  typedef enum logic [2:0] {
    ST_CFG   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_RAMPC = 3'd2,
    ST_CAL   = 3'd3,
    ST_RAMP  = 3'd4,
    ST_LEAK  = 3'd5,
    ST_ACT   = 3'd6,
    ST_FLT   = 3'd7
  } seq_st_t;

  localparam int NWORDS = 4;
  // configuration word indices
  localparam int W_STEP  = 0;
  localparam int W_FLAGS = 1;
  localparam int W_CAL   = 2;
  localparam int W_TMO   = 3;
  // bit positions inside the flags word
  localparam int F_UVLO  = 0;
  localparam int F_CAL   = 1;
  localparam int F_MODE  = 2;

  function automatic logic is_run(seq_st_t s);
    return (s == ST_RAMPC) || (s == ST_CAL) || (s == ST_RAMP) ||
           (s == ST_LEAK) || (s == ST_ACT);
  endfunction

endpackage

// File: rtl/vr_cfg_fetch.sv
module vr_cfg_fetch #(
  parameter int DW = 16,
  parameter int AW = 2,
  parameter int NW = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  output logic                   rd,
  output logic [AW-1:0]          addr,
  input  logic [DW-1:0]          rdata,
  output logic [NW-1:0][DW-1:0]  words,
  output logic                   done
);
  localparam int CW = $clog2(NW + 1);

  logic [CW-1:0]         issue_q;
  logic                  rd_q;
  logic [AW-1:0]         addr_q;
  logic                  cap_q;
  logic [AW-1:0]         cidx_q;
  logic [NW-1:0][DW-1:0] words_q;
  logic                  done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_q <= '0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      cap_q   <= 1'b0;
      cidx_q  <= '0;
      words_q <= '0;
      done_q  <= 1'b0;
    end else begin
      cap_q  <= rd_q;
      cidx_q <= addr_q;
      if (issue_q < CW'(NW)) begin
        rd_q    <= 1'b1;
        addr_q  <= AW'(issue_q);
        issue_q <= issue_q + 1'b1;
      end else begin
        rd_q <= 1'b0;
      end
      if (cap_q) begin
        words_q[cidx_q] <= rdata;
        if (cidx_q == AW'(NW - 1)) done_q <= 1'b1;
      end
    end
  end

  assign rd    = rd_q;
  assign addr  = addr_q;
  assign words = words_q;
  assign done  = done_q;

  // R2
  fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_q && $past(rd_q)) |-> (addr_q == $past(addr_q) + AW'(1)));

endmodule

// File: rtl/vr_ramp.sv
module vr_ramp #(
  parameter int W  = 6,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run,
  input  logic [W-1:0]  goal,
  input  logic [IW-1:0] interval,
  output logic [W-1:0]  target
);
  logic [W-1:0]  tgt_q;
  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tgt_q <= '0;
      cnt_q <= '0;
    end else if (run && (tgt_q < goal)) begin
      if (cnt_q == interval) begin
        cnt_q <= '0;
        tgt_q <= tgt_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign target = tgt_q;

  // R6
  ramp_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && run) |=> (tgt_q >= $past(tgt_q)) && (tgt_q - $past(tgt_q) <= W'(1)));

endmodule

// File: rtl/vr_wait_timer.sv
module vr_wait_timer #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          done,
  input  logic [LW-1:0] limit,
  output logic          expired
);
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !active || done) cnt_q <= '0;
    else if (cnt_q != '1)       cnt_q <= cnt_q + 1'b1;
  end

  assign expired = active && !done && (cnt_q == limit);

  // R10
  tmo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt_q <= limit));

endmodule

// File: rtl/vr_powerup_seq.sv
module vr_powerup_seq
  import vr_seq_pkg::*;
#(
  parameter int VID_W  = 6,
  parameter int NPH    = 2,
  parameter int NVM_DW = 16,
  parameter int NVM_AW = 2,
  parameter int STEP_W = 8,
  parameter int LIM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_rst_n,
  output logic              nvm_rd,
  output logic [NVM_AW-1:0] nvm_addr,
  input  logic [NVM_DW-1:0] nvm_rdata,
  input  logic [VID_W-1:0]  vcode,
  input  logic              run_en,
  input  logic              vin_above,
  input  logic              meas_done,
  output logic [VID_W-1:0]  target,
  output logic              pwr_ok,
  output logic [NPH-1:0]    ph_oe,
  output logic [NPH-1:0]    ph_val,
  output logic [NPH-1:0]    cal_sel,
  output logic              leak_en,
  output logic              cal_fault,
  output logic [2:0]        seq_state
);
  localparam int PHW = (NPH > 1) ? $clog2(NPH) : 1;

  logic rst_i;
  assign rst_i = rst | ~ext_rst_n;

  // configuration fetch
  logic [NWORDS-1:0][NVM_DW-1:0] cfg_w;
  logic                          cfg_done;

  vr_cfg_fetch #(.DW(NVM_DW), .AW(NVM_AW), .NW(NWORDS)) u_fetch (
    .clk(clk), .rst(rst_i), .rd(nvm_rd), .addr(nvm_addr),
    .rdata(nvm_rdata), .words(cfg_w), .done(cfg_done)
  );

  logic [STEP_W-1:0] step_iv;
  logic              uvlo_en, cal_en;
  logic [VID_W-1:0]  cal_code;
  logic [LIM_W-1:0]  tmo_lim;
  logic              unused_cfg_bits;

  assign step_iv         = cfg_w[W_STEP][STEP_W-1:0];
  assign uvlo_en         = cfg_w[W_FLAGS][F_UVLO];
  assign cal_en          = cfg_w[W_FLAGS][F_CAL];
  assign cal_code        = cfg_w[W_CAL][VID_W-1:0];
  assign tmo_lim         = cfg_w[W_TMO][LIM_W-1:0];
  assign unused_cfg_bits = ^cfg_w;

  // per-phase inactive defaults
  logic [NPH-1:0] dflt_oe, dflt_val;
  for (genvar k = 0; k < NPH; k++) begin : g_dflt
    logic [1:0] mode;
    assign mode       = cfg_w[W_FLAGS][F_MODE + 2*k +: 2];
    assign dflt_oe[k]  = ~mode[1];
    assign dflt_val[k] = (mode == 2'b01);
  end

  // start and hold conditions
  logic supply_ok, hold_ok, start_ok;
  assign supply_ok = !uvlo_en || vin_above;
  assign hold_ok   = run_en && supply_ok;
  assign start_ok  = hold_ok && (vcode != '1);

  seq_st_t          state_q, nxt;
  logic [VID_W-1:0] vcode_q;
  logic [PHW-1:0]   ph_q, ph_d;

  // ramp generator
  logic [VID_W-1:0] cal_goal, ramp_goal, tgt;
  logic             ramp_clr, ramp_run;

  assign cal_goal  = (cal_code < vcode_q) ? cal_code : vcode_q;
  assign ramp_goal = (state_q == ST_RAMPC) ? cal_goal : vcode_q;
  assign ramp_run  = (state_q == ST_RAMPC) || (state_q == ST_RAMP);
  assign ramp_clr  = !is_run(nxt);

  vr_ramp #(.W(VID_W), .IW(STEP_W)) u_ramp (
    .clk(clk), .rst(rst_i), .clr(ramp_clr), .run(ramp_run),
    .goal(ramp_goal), .interval(step_iv), .target(tgt)
  );

  // measurement timeout
  logic wait_act, expired;
  assign wait_act = (state_q == ST_CAL) || (state_q == ST_LEAK);

  vr_wait_timer #(.LW(LIM_W)) u_tmo (
    .clk(clk), .rst(rst_i), .active(wait_act), .done(meas_done),
    .limit(tmo_lim), .expired(expired)
  );

  // next state
  always_comb begin
    nxt = state_q;
    case (state_q)
      ST_CFG:   if (cfg_done) nxt = ST_IDLE;
      ST_IDLE:  if (start_ok) nxt = cal_en ? ST_RAMPC : ST_RAMP;
      ST_RAMPC: if (tgt == cal_goal) nxt = ST_CAL;
      ST_CAL: begin
        if (expired) nxt = ST_FLT;
        else if (meas_done && (ph_q == PHW'(NPH - 1))) nxt = ST_RAMP;
      end
      ST_RAMP:  if (tgt == vcode_q) nxt = ST_LEAK;
      ST_LEAK: begin
        if (expired)        nxt = ST_FLT;
        else if (meas_done) nxt = ST_ACT;
      end
      default:  nxt = state_q;
    endcase
    if (is_run(state_q) && !hold_ok) nxt = ST_IDLE;
  end

  always_comb begin
    if (nxt != ST_CAL)                       ph_d = '0;
    else if (state_q == ST_CAL && meas_done) ph_d = ph_q + 1'b1;
    else                                     ph_d = ph_q;
  end

  // registered outputs
  logic [NPH-1:0] oe_q, val_q, sel_q;
  logic           leak_q, pok_q, flt_q;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      state_q <= ST_CFG;
      ph_q    <= '0;
      vcode_q <= '0;
      sel_q   <= '0;
      leak_q  <= 1'b0;
      pok_q   <= 1'b0;
      flt_q   <= 1'b0;
      oe_q    <= '0;
      val_q   <= '0;
    end else begin
      state_q <= nxt;
      ph_q    <= ph_d;
      if (state_q == ST_IDLE && start_ok) vcode_q <= vcode;
      sel_q   <= (nxt == ST_CAL) ? (NPH'(1) << ph_d) : '0;
      leak_q  <= (nxt == ST_LEAK);
      pok_q   <= (nxt == ST_ACT);
      flt_q   <= (nxt == ST_FLT);
      if (nxt == ST_CFG) begin
        oe_q  <= '0;
        val_q <= '0;
      end else if (is_run(nxt)) begin
        oe_q  <= '1;
        val_q <= '1;
      end else begin
        oe_q  <= dflt_oe;
        val_q <= dflt_val;
      end
    end
  end

  assign target    = tgt;
  assign pwr_ok    = pok_q;
  assign ph_oe     = oe_q;
  assign ph_val    = val_q;
  assign cal_sel   = sel_q;
  assign leak_en   = leak_q;
  assign cal_fault = flt_q;
  assign seq_state = state_q;

  // R1
  cfg_hiz_chk: assert property (@(posedge clk) disable iff (rst_i)
    (state_q == ST_CFG) |-> (oe_q == '0) && !pok_q && (tgt == '0));

  // R9
  pgood_state_chk: assert property (@(posedge clk) disable iff (rst_i)
    pok_q |-> (state_q == ST_ACT));

  // R6
  ramp_step_chk: assert property (@(posedge clk) disable iff (rst_i)
    (state_q == ST_RAMP && $past(state_q) == ST_RAMP) |->
      (tgt == $past(tgt)) || (tgt == $past(tgt) + VID_W'(1)));

  // R7
  cal_onehot_chk: assert property (@(posedge clk) disable iff (rst_i)
    $onehot0(sel_q) && ((sel_q != '0) -> (state_q == ST_CAL)));

  // R11
  drop_idle_chk: assert property (@(posedge clk) disable iff (rst_i)
    (is_run(state_q) && !(run_en && supply_ok)) |=>
      (state_q == ST_IDLE) && !pok_q && (tgt == '0) && (sel_q == '0));

  // R10
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst_i)
    flt_q |-> (state_q == ST_FLT) && (tgt == '0));

endmodule

// File: tb/test_vr_powerup_seq.sv
module test_vr_powerup_seq;
  localparam int VW = 6;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ext_rst_n = 1'b1;
  logic          nvm_rd;
  logic [1:0]    nvm_addr;
  logic [15:0]   nvm_rdata = '0;
  logic [VW-1:0] vcode = '0;
  logic          run_en = 1'b0;
  logic          vin_above = 1'b1;
  logic          meas_done = 1'b0;
  logic [VW-1:0] target;
  logic          pwr_ok;
  logic [NP-1:0] ph_oe, ph_val, cal_sel;
  logic          leak_en, cal_fault;
  logic [2:0]    seq_state;

  always #10 clk = ~clk;

  vr_powerup_seq #(.VID_W(VW), .NPH(NP), .NVM_DW(16), .NVM_AW(2)) i_vr_powerup_seq (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .nvm_rd(nvm_rd), .nvm_addr(nvm_addr),
    .nvm_rdata(nvm_rdata), .vcode(vcode), .run_en(run_en), .vin_above(vin_above),
    .meas_done(meas_done), .target(target), .pwr_ok(pwr_ok), .ph_oe(ph_oe),
    .ph_val(ph_val), .cal_sel(cal_sel), .leak_en(leak_en), .cal_fault(cal_fault),
    .seq_state(seq_state)
  );

  // NVM model with one cycle of read latency
  logic [15:0] mem [4];
  always @(posedge clk) if (nvm_rd) nvm_rdata <= mem[nvm_addr];

  int errs = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // measurement responder
  bit  resp_on = 1'b1;
  int  resp_dly = 1;
  int  rcnt = 0;
  logic [NP:0] req_last = '0;
  always @(negedge clk) begin
    logic [NP:0] req;
    req = {leak_en, cal_sel};
    if (req != '0 && req == req_last) rcnt++;
    else rcnt = 0;
    req_last = req;
    meas_done = resp_on && (req != '0) && (rcnt == resp_dly);
  end

  // NVM address recorder
  int rec_n = 0;
  int rec [8];
  always @(negedge clk) if (nvm_rd && rec_n < 8) begin rec[rec_n] = int'(nvm_addr); rec_n++; end

  function automatic logic [15:0] flags(bit uv, bit cal, int m0, int m1);
    return 16'(uv) | (16'(cal) << 1) | (16'(m0) << 2) | (16'(m1) << 4);
  endfunction

  task automatic do_reset(input logic [15:0] w0, w1, w2, w3, input bit ext);
    bit cfg_ok;
    int n;
    mem[0] = w0; mem[1] = w1; mem[2] = w2; mem[3] = w3;
    @(negedge clk);
    run_en = 1'b0;
    if (ext) ext_rst_n = 1'b0; else rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(seq_state == 0 && ph_oe == 0 && !pwr_ok && target == 0, "R1", "reset state", int'(seq_state), 0);
    rec_n = 0;
    rst = 1'b0; ext_rst_n = 1'b1;
    cfg_ok = 1'b1; n = 0;
    while (seq_state != 1 && n < 40) begin
      @(negedge clk); n++;
      if (seq_state == 0 && (ph_oe != 0 || pwr_ok || target != 0)) cfg_ok = 1'b0;
    end
    chk(cfg_ok, "R1", "outputs off during config", int'(ph_oe), 0);
    chk(seq_state == 1, "R2", "inactive after config", int'(seq_state), 1);
    chk(rec_n == 4 && rec[0] == 0 && rec[1] == 1 && rec[2] == 2 && rec[3] == 3,
        "R2", "nvm read order", rec_n, 4);
  endtask

  task automatic run_case(input int iv, input bit cal, input int vc, input int cc, input int dly, input int lim);
    int cyc, last, prev_t, nph, s, t, exp_cal;
    int ph_log [4];
    logic [NP-1:0] prev_sel;
    bit step_bad, gap_bad, pg_early, leak_seen, oe_bad, calt_bad, pg_entry;
    resp_on = 1'b1; resp_dly = dly; vin_above = 1'b1;
    do_reset(16'(iv), flags(0, cal, 0, 0), 16'(cc), 16'(lim), 0);
    exp_cal = (cc < vc) ? cc : vc;
    cyc = 0; last = -1; prev_t = 0; nph = 0; prev_sel = '0;
    step_bad = 0; gap_bad = 0; pg_early = 0; leak_seen = 0; oe_bad = 0; calt_bad = 0; pg_entry = 0;
    vcode = VW'(vc); run_en = 1'b1;
    while (cyc < 3000) begin
      @(negedge clk); cyc++;
      s = int'(seq_state); t = int'(target);
      if (t != prev_t) begin
        if (t != prev_t + 1) step_bad = 1;
        if (last >= 0 && cyc - last != iv + 1) gap_bad = 1;
        last = cyc;
      end
      if (s != 2 && s != 4) last = -1;
      if (cal_sel != '0 && cal_sel != prev_sel) begin
        if (nph < 4) ph_log[nph] = (cal_sel == 2'b10) ? 1 : ((cal_sel == 2'b01) ? 0 : 9);
        nph++;
        if (t != exp_cal) calt_bad = 1;
      end
      prev_sel = cal_sel;
      if (s >= 2 && s <= 6 && (ph_oe != '1 || ph_val != '1)) oe_bad = 1;
      if (leak_en) leak_seen = 1;
      if (s != 6 && pwr_ok) pg_early = 1;
      prev_t = t;
      if (s == 6) begin pg_entry = pwr_ok; break; end
    end
    chk(seq_state == 6, "R9", "reached active", int'(seq_state), 6);
    chk(pg_entry && !pg_early, "R9", "power-good on entry only", int'(pg_entry), 1);
    chk(leak_seen, "R9", "leakage step ran", int'(leak_seen), 1);
    chk(int'(target) == vc, "R6", "final target", int'(target), vc);
    chk(!step_bad, "R6", "single LSB monotonic steps", int'(step_bad), 0);
    chk(!gap_bad, "R6", "step spacing", int'(gap_bad), 0);
    chk(!oe_bad, "R12", "phases driven while running", int'(oe_bad), 0);
    if (cal) begin
      chk(nph == NP && ph_log[0] == 0 && ph_log[1] == 1, "R7", "phase order", nph, NP);
      chk(!calt_bad, "R7", "calibration level", int'(calt_bad), 0);
    end else begin
      chk(nph == 0, "R8", "no calibration", nph, 0);
    end
  endtask

  task automatic tmo_case(input bit cal, input int lim);
    int n, ws, g;
    resp_on = 1'b0; vin_above = 1'b1;
    do_reset(16'd0, flags(0, cal, 0, 0), 16'd3, 16'(lim), 0);
    vcode = 6'd10; run_en = 1'b1;
    ws = cal ? 3 : 5;
    n = 0; g = 0;
    while (seq_state != 7 && g < 1000) begin
      @(negedge clk); g++;
      if (int'(seq_state) == ws) n++;
    end
    chk(n == lim + 1, "R10", "cycles before fault", n, lim + 1);
    chk(cal_fault && target == 0 && !pwr_ok, "R10", "fault outputs", int'(cal_fault), 1);
    resp_on = 1'b1;
    repeat (6) @(negedge clk);
    chk(seq_state == 7, "R10", "fault held", int'(seq_state), 7);
    resp_on = 1'b1;
  endtask

  task automatic wait_for(input int st, input int min_t);
    int g;
    g = 0;
    while (!(int'(seq_state) == st && int'(target) >= min_t) && g < 1000) begin
      @(negedge clk); g++;
    end
  endtask

  initial begin
    // reset, config and inactive defaults (R1 R2 R3)
    for (int m0 = 0; m0 < 4; m0++) begin
      for (int m1 = 0; m1 < 4; m1++) begin
        do_reset(16'd0, flags(0, 0, m0, m1), 16'd0, 16'd10, (m0 == m1));
        chk(ph_oe == {~m1[1], ~m0[1]} && ph_val == {(m1 == 1), (m0 == 1)},
            "R3", "inactive defaults", int'({ph_oe, ph_val}), m0 * 4 + m1);
      end
    end

    // start gating (R4 R5)
    do_reset(16'd0, flags(1, 0, 0, 0), 16'd0, 16'd20, 0);
    vcode = 6'd5; vin_above = 1'b1; run_en = 1'b0;
    repeat (8) @(negedge clk);
    chk(seq_state == 1, "R4", "no start without run_en", int'(seq_state), 1);
    vcode = '1; run_en = 1'b1;
    repeat (8) @(negedge clk);
    chk(seq_state == 1, "R4", "no start with invalid code", int'(seq_state), 1);
    vcode = 6'd5; vin_above = 1'b0;
    repeat (8) @(negedge clk);
    chk(seq_state == 1, "R5", "no start under lockout", int'(seq_state), 1);
    vin_above = 1'b1;
    @(negedge clk);
    chk(seq_state == 4, "R4", "start when all hold", int'(seq_state), 4);
    do_reset(16'd0, flags(0, 0, 0, 0), 16'd0, 16'd20, 0);
    vin_above = 1'b0; vcode = 6'd5; run_en = 1'b1;
    @(negedge clk);
    chk(seq_state == 4, "R5", "comparator ignored when lockout off", int'(seq_state), 4);
    repeat (3) @(negedge clk);
    chk(seq_state == 4, "R5", "still running with comparator low", int'(seq_state), 4);

    // ramp and calibration sweep (R6 R7 R8 R9 R12)
    for (int iv = 0; iv < 3; iv++)
      for (int cal = 0; cal < 2; cal++)
        foreach (mem[j]) begin
          int vc;
          vc = (j == 0) ? 0 : ((j == 1) ? 1 : ((j == 2) ? 9 : 20));
          run_case(iv, cal[0], vc, 4, 2, 50);
        end

    // timeout (R10)
    tmo_case(1, 5);
    tmo_case(0, 0);
    tmo_case(0, 5);
    run_case(0, 1, 6, 2, 3, 3);
    chk(seq_state == 6 && !cal_fault, "R10", "reply in last allowed cycle accepted", int'(seq_state), 6);

    // drop back to inactive (R11)
    resp_on = 1'b1; resp_dly = 1; vin_above = 1'b1;
    do_reset(16'd1, flags(1, 1, 0, 0), 16'd3, 16'd50, 0);
    vcode = 6'd12; run_en = 1'b1;
    wait_for(3, 0);
    run_en = 1'b0;
    @(negedge clk);
    chk(seq_state == 1 && target == 0 && cal_sel == 0, "R11", "drop in calibration", int'(seq_state), 1);
    run_en = 1'b1;
    wait_for(4, 5);
    run_en = 1'b0;
    @(negedge clk);
    chk(seq_state == 1 && target == 0 && !pwr_ok, "R11", "drop in ramp", int'(target), 0);
    run_en = 1'b1;
    wait_for(6, 0);
    chk(pwr_ok, "R9", "active before supply loss", int'(pwr_ok), 1);
    vin_above = 1'b0;
    @(negedge clk);
    chk(seq_state == 1 && target == 0 && !pwr_ok, "R11", "supply loss in active", int'(seq_state), 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule